// File: doc/BRIEF.md
# Replacement Way Selector for a Set-Associative Cache

This block decides which way of one cache set receives a new line after a miss. It holds replacement bookkeeping for every set of an N-way set-associative cache (2, 4 or 6 ways, with any number of sets). The surrounding cache controller reports three kinds of event: a hit on a way, a fill of a way, or an invalidation of a way. Each event names a set and a way. The bookkeeping for that set is updated on the next rising clock edge.

To choose a victim, the controller presents a set index and that set's per-way valid bits. The block then returns a way number with no clock edge in between. A way that holds no line is always chosen before any live line is evicted. When every way is occupied, a policy input picks the rule, and it can be changed on any cycle:
- oldest load (first-in first-out),
- oldest access (least recently used), or
- fewest accesses (least frequently used).

Load order and access order are both kept as per-set ranks, from 0 (oldest) to N-1 (newest). Use counts are small saturating counters, and they are halved as a group when one of them saturates.

Top module: `victim_way_sel`

## Requirements
- R1: When any bit of `req_valid_i` is 0, `victim_way_o` is the lowest-numbered way whose valid bit is 0, whatever the policy.
- R2: Policy code 0 (first-in first-out). With all ways valid, the victim is the way of the set whose last fill is oldest. Hit events do not change this order.
- R3: Policy code 1 (least recently used). With all ways valid, the victim is the way whose last hit or fill is oldest. Policy code 3 behaves the same as code 1.
- R4: Policy code 2 (least frequently used). With all ways valid, the victim is the way with the smallest use count. A hit adds one to the count of the hit way. Ties go to the lowest way number.
- R5: A fill event (kind code 1) sets that way's use count to 1 and makes it the newest way in both load order and access order.
- R6: An invalidate event (kind code 2) sets that way's use count to 0 and leaves both rank orders unchanged. A hit is kind code 0, and kind code 3 does nothing.
- R7: A hit on a way whose count is at its maximum (2^CNT_W-1) does not wrap. Instead, every count in that set is halved (rounded down), and the hit way's count then becomes half the maximum plus one.
- R8: After reset, every set has use count 0 in every way. In every set, both rank orders start with way 0 as the oldest and way N-1 as the newest.
- R9: An event changes the bookkeeping of the set it names and no other set.
- R10: `victim_way_o` is a combinational function of the stored state and the request inputs. An event takes effect on the rising edge at which `evt_valid_i` is sampled high, and not earlier.
- R11: A change of `policy_i` changes `victim_way_o` in the same cycle, with no update of state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| policy_i | input | 2 | Replacement rule: 0 load order, 1 or 3 access order, 2 use count |
| evt_valid_i | input | 1 | An event is present this cycle |
| evt_kind_i | input | 2 | 0 hit, 1 fill, 2 invalidate, 3 no operation |
| evt_set_i | input | $clog2(NUM_SETS) | Set touched by the event |
| evt_way_i | input | $clog2(NUM_WAYS) | Way touched by the event; values of NUM_WAYS or more are ignored |
| req_set_i | input | $clog2(NUM_SETS) | Set for which a victim is requested |
| req_valid_i | input | NUM_WAYS | Valid bit of each way of the requested set |
| victim_way_o | output | $clog2(NUM_WAYS) | Way chosen for the next fill |

## Verification
The bench aims at these cases:
- Partly full sets. Picking any free way other than the lowest would return the wrong way number.
- Hits while the first-in first-out rule is active. A design that advanced load order on hits would evict a recently hit line too early.
- Refills of a way with a high count. If the count were not reset to 1, that way would keep its old count and another way would be evicted.
- Saturation. It is driven until one counter tops out, then followed by more hits. A wrapping counter would make the busiest way the victim. A counter that only sticks at the maximum, without halving the others, would produce a different choice once newer hits arrive.
- Timing and scope. The victim must not change before the edge that takes the event, and an event in one set must leave the answer for another set unchanged.

// File: rtl/vws_pkg.sv
package vws_pkg;

    typedef enum logic [1:0] {
        POL_FIFO = 2'd0,
        POL_LRU  = 2'd1,
        POL_LFU  = 2'd2,
        POL_ALT  = 2'd3
    } policy_e;

    typedef enum logic [1:0] {
        EV_HIT   = 2'd0,
        EV_FILL  = 2'd1,
        EV_INVAL = 2'd2,
        EV_NOP   = 2'd3
    } event_e;

    // Returns 1 when the way count is one the block supports.
    function automatic bit ways_supported(input int n);
        return (n == 2) || (n == 4) || (n == 6);
    endfunction

endpackage

// File: rtl/vws_rank_tracker.sv
module vws_rank_tracker #(
    parameter  int NUM_SETS = 16,
    parameter  int NUM_WAYS = 4,
    localparam int SET_W    = $clog2(NUM_SETS),
    localparam int WAY_W    = $clog2(NUM_WAYS),
    localparam int RANK_W   = $clog2(NUM_WAYS)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             touch_en,
    input  logic [SET_W-1:0]                 touch_set,
    input  logic [WAY_W-1:0]                 touch_way,
    input  logic [SET_W-1:0]                 rd_set,
    output logic [NUM_WAYS-1:0][RANK_W-1:0]  rd_ranks
);

    localparam logic [RANK_W-1:0] NEWEST = RANK_W'(NUM_WAYS - 1);

    logic [RANK_W-1:0] rank_q [NUM_SETS][NUM_WAYS];
    logic [RANK_W-1:0] touched_rank;
    logic [NUM_WAYS-1:0] oldest_vec;

    always_comb begin
        touched_rank = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (WAY_W'(w) == touch_way) touched_rank = rank_q[touch_set][w];
        end
    end

    // Touched way becomes newest; ways that were younger move one step older.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                for (int w = 0; w < NUM_WAYS; w++) begin
                    rank_q[s][w] <= RANK_W'(w);
                end
            end
        end else if (touch_en) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
                if (WAY_W'(w) == touch_way) begin
                    rank_q[touch_set][w] <= NEWEST;
                end else if (rank_q[touch_set][w] > touched_rank) begin
                    rank_q[touch_set][w] <= rank_q[touch_set][w] - RANK_W'(1);
                end
            end
        end
    end

    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_rd
        assign rd_ranks[g]   = rank_q[rd_set][g];
        assign oldest_vec[g] = (rank_q[rd_set][g] == '0);
    end

    // R10: a touched way reads as newest right after the edge that took it
    p_touch_newest_r10: assert property (@(posedge clk) disable iff (rst)
        touch_en |=> (rank_q[$past(touch_set)][$past(touch_way)] == NEWEST));

    // R2 / R3: exactly one way of the read set holds the oldest rank
    p_single_oldest_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(oldest_vec) == 1);

endmodule

// File: rtl/vws_lfu_bank.sv
module vws_lfu_bank
    import vws_pkg::*;
#(
    parameter  int NUM_SETS = 16,
    parameter  int NUM_WAYS = 4,
    parameter  int CNT_W    = 3,
    localparam int SET_W    = $clog2(NUM_SETS),
    localparam int WAY_W    = $clog2(NUM_WAYS)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            ev_en,
    input  logic [1:0]                      ev_kind,
    input  logic [SET_W-1:0]                ev_set,
    input  logic [WAY_W-1:0]                ev_way,
    input  logic [SET_W-1:0]                rd_set,
    output logic [NUM_WAYS-1:0][CNT_W-1:0]  rd_cnts
);

    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_HALF = (CNT_MAX >> 1) + CNT_W'(1);

    logic [CNT_W-1:0] cnt_q [NUM_SETS][NUM_WAYS];
    logic [CNT_W-1:0] cur_cnt;
    logic             at_max;

    always_comb begin
        cur_cnt = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (WAY_W'(w) == ev_way) cur_cnt = cnt_q[ev_set][w];
        end
        at_max = (cur_cnt == CNT_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                for (int w = 0; w < NUM_WAYS; w++) begin
                    cnt_q[s][w] <= '0;
                end
            end
        end else if (ev_en) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
                unique case (ev_kind)
                    EV_HIT: begin
                        if (at_max) begin
                            cnt_q[ev_set][w] <= (WAY_W'(w) == ev_way) ? CNT_HALF
                                                                      : (cnt_q[ev_set][w] >> 1);
                        end else if (WAY_W'(w) == ev_way) begin
                            cnt_q[ev_set][w] <= cnt_q[ev_set][w] + CNT_W'(1);
                        end
                    end
                    EV_FILL:  if (WAY_W'(w) == ev_way) cnt_q[ev_set][w] <= CNT_W'(1);
                    EV_INVAL: if (WAY_W'(w) == ev_way) cnt_q[ev_set][w] <= '0;
                    default: ;
                endcase
            end
        end
    end

    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_rd
        assign rd_cnts[g] = cnt_q[rd_set][g];
    end

    // R5: a fill leaves the count at one
    p_fill_one_r5: assert property (@(posedge clk) disable iff (rst)
        (ev_en && ev_kind == EV_FILL) |=> (cnt_q[$past(ev_set)][$past(ev_way)] == CNT_W'(1)));

    // R6: an invalidate leaves the count at zero
    p_inval_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (ev_en && ev_kind == EV_INVAL) |=> (cnt_q[$past(ev_set)][$past(ev_way)] == '0));

    // R7: a hit never leaves its way at zero (no wrap)
    p_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (ev_en && ev_kind == EV_HIT) |=> (cnt_q[$past(ev_set)][$past(ev_way)] != '0));

endmodule

// File: rtl/vws_victim_pick.sv
module vws_victim_pick
    import vws_pkg::*;
#(
    parameter  int NUM_WAYS = 4,
    parameter  int CNT_W    = 3,
    localparam int WAY_W    = $clog2(NUM_WAYS),
    localparam int RANK_W   = $clog2(NUM_WAYS)
) (
    input  logic [1:0]                       policy,
    input  logic [NUM_WAYS-1:0]              valid,
    input  logic [NUM_WAYS-1:0][RANK_W-1:0]  load_ranks,
    input  logic [NUM_WAYS-1:0][RANK_W-1:0]  use_ranks,
    input  logic [NUM_WAYS-1:0][CNT_W-1:0]   cnts,
    output logic [WAY_W-1:0]                 victim
);

    logic             any_free;
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] load_way;
    logic [WAY_W-1:0] use_way;
    logic [WAY_W-1:0] lfu_way;
    logic [CNT_W-1:0] best_cnt;

    always_comb begin
        any_free = ~&valid;
        free_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) free_way = WAY_W'(w);
        end

        load_way = '0;
        use_way  = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (load_ranks[w] == '0) load_way = WAY_W'(w);
            if (use_ranks[w]  == '0) use_way  = WAY_W'(w);
        end

        lfu_way  = '0;
        best_cnt = cnts[0];
        for (int w = 1; w < NUM_WAYS; w++) begin
            if (cnts[w] < best_cnt) begin
                best_cnt = cnts[w];
                lfu_way  = WAY_W'(w);
            end
        end

        if (any_free) begin
            victim = free_way;
        end else begin
            unique case (policy)
                POL_FIFO: victim = load_way;
                POL_LFU:  victim = lfu_way;
                default:  victim = use_way;
            endcase
        end
    end

endmodule

// File: rtl/victim_way_sel.sv
module victim_way_sel
    import vws_pkg::*;
#(
    parameter  int NUM_SETS = 16,
    parameter  int NUM_WAYS = 4,
    parameter  int CNT_W    = 3,
    localparam int SET_W    = $clog2(NUM_SETS),
    localparam int WAY_W    = $clog2(NUM_WAYS),
    localparam int RANK_W   = $clog2(NUM_WAYS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           policy_i,
    input  logic                 evt_valid_i,
    input  logic [1:0]           evt_kind_i,
    input  logic [SET_W-1:0]     evt_set_i,
    input  logic [WAY_W-1:0]     evt_way_i,
    input  logic [SET_W-1:0]     req_set_i,
    input  logic [NUM_WAYS-1:0]  req_valid_i,
    output logic [WAY_W-1:0]     victim_way_o
);

    initial begin
        if (!ways_supported(NUM_WAYS)) $error("NUM_WAYS must be 2, 4 or 6");
    end

    logic evt_ok;
    logic load_touch;
    logic use_touch;

    logic [NUM_WAYS-1:0][RANK_W-1:0] load_ranks;
    logic [NUM_WAYS-1:0][RANK_W-1:0] use_ranks;
    logic [NUM_WAYS-1:0][CNT_W-1:0]  cnts;
    logic [NUM_WAYS-1:0]             below_victim;

    assign evt_ok     = evt_valid_i && (int'(evt_way_i) < NUM_WAYS);
    assign load_touch = evt_ok && (evt_kind_i == EV_FILL);
    assign use_touch  = evt_ok && ((evt_kind_i == EV_FILL) || (evt_kind_i == EV_HIT));

    vws_rank_tracker #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) load_order_i (
        .clk       (clk),
        .rst       (rst),
        .touch_en  (load_touch),
        .touch_set (evt_set_i),
        .touch_way (evt_way_i),
        .rd_set    (req_set_i),
        .rd_ranks  (load_ranks)
    );

    vws_rank_tracker #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) use_order_i (
        .clk       (clk),
        .rst       (rst),
        .touch_en  (use_touch),
        .touch_set (evt_set_i),
        .touch_way (evt_way_i),
        .rd_set    (req_set_i),
        .rd_ranks  (use_ranks)
    );

    vws_lfu_bank #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .CNT_W(CNT_W)) use_count_i (
        .clk     (clk),
        .rst     (rst),
        .ev_en   (evt_ok),
        .ev_kind (evt_kind_i),
        .ev_set  (evt_set_i),
        .ev_way  (evt_way_i),
        .rd_set  (req_set_i),
        .rd_cnts (cnts)
    );

    vws_victim_pick #(.NUM_WAYS(NUM_WAYS), .CNT_W(CNT_W)) pick_i (
        .policy     (policy_i),
        .valid      (req_valid_i),
        .load_ranks (load_ranks),
        .use_ranks  (use_ranks),
        .cnts       (cnts),
        .victim     (victim_way_o)
    );

    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_below
        assign below_victim[g] = (WAY_W'(g) < victim_way_o);
    end

    // R1: a free way is chosen when one exists
    p_free_chosen_r1: assert property (@(posedge clk) disable iff (rst)
        (~&req_valid_i) |-> !req_valid_i[victim_way_o]);

    // R1: every way below the chosen free way is occupied
    p_lowest_free_r1: assert property (@(posedge clk) disable iff (rst)
        (~&req_valid_i) |-> ((req_valid_i & below_victim) == below_victim));

    // R10: the output always names an existing way
    p_victim_range_r10: assert property (@(posedge clk) disable iff (rst)
        int'(victim_way_o) < NUM_WAYS);

    // R11: with the state and request held, the output moves only when the policy moves
    p_policy_only_r11: assert property (@(posedge clk) disable iff (rst)
        ($past(!evt_valid_i) && $stable(req_set_i) && $stable(req_valid_i) && $stable(policy_i))
            |-> $stable(victim_way_o));

endmodule

// File: tb/victim_way_sel_tb.sv
module victim_way_sel_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NSETS = 16;
    localparam int NWAYS = 4;
    localparam int CW    = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] policy_i = '0;
    logic       evt_valid_i = 1'b0;
    logic [1:0] evt_kind_i = '0;
    logic [3:0] evt_set_i = '0;
    logic [1:0] evt_way_i = '0;
    logic [3:0] req_set_i = '0;
    logic [3:0] req_valid_i = '0;
    logic [1:0] victim_way_o;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    victim_way_sel #(.NUM_SETS(NSETS), .NUM_WAYS(NWAYS), .CNT_W(CW)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .policy_i     (policy_i),
        .evt_valid_i  (evt_valid_i),
        .evt_kind_i   (evt_kind_i),
        .evt_set_i    (evt_set_i),
        .evt_way_i    (evt_way_i),
        .req_set_i    (req_set_i),
        .req_valid_i  (req_valid_i),
        .victim_way_o (victim_way_o)
    );

    // Fields: [16] event, [15:14] kind, [13:10] set, [9:8] way, [7:6] policy, [5:2] valid, [1:0] expected.
    // Kind 0 hit / 1 fill / 2 invalidate. Policy 0 load order, 1 access order, 2 use count.
    localparam int NV = 23;
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 2'd0, 4'd0, 2'd0, 2'd0, 4'b0000, 2'd0},  // R1 all free
        {1'b0, 2'd0, 4'd0, 2'd0, 2'd0, 4'b0101, 2'd1},  // R1 lowest free way 1
        {1'b0, 2'd0, 4'd0, 2'd0, 2'd1, 4'b1011, 2'd2},  // R1 free way 2 under access order
        {1'b0, 2'd0, 4'd0, 2'd0, 2'd0, 4'b1111, 2'd0},  // R8 reset load order
        {1'b0, 2'd0, 4'd0, 2'd0, 2'd2, 4'b1111, 2'd0},  // R8 reset counts
        {1'b1, 2'd1, 4'd0, 2'd2, 2'd0, 4'b1111, 2'd0},  // R2 fill 2
        {1'b1, 2'd1, 4'd0, 2'd0, 2'd0, 4'b1111, 2'd1},  // R2 fill 0
        {1'b1, 2'd1, 4'd0, 2'd3, 2'd0, 4'b1111, 2'd1},  // R2 fill 3
        {1'b1, 2'd1, 4'd0, 2'd1, 2'd0, 4'b1111, 2'd2},  // R2 fill 1, oldest load is 2
        {1'b0, 2'd0, 4'd0, 2'd0, 2'd1, 4'b1111, 2'd2},  // R3 oldest access is 2
        {1'b0, 2'd0, 4'd0, 2'd0, 2'd2, 4'b1111, 2'd0},  // R4 all counts one, tie low
        {1'b1, 2'd0, 4'd0, 2'd2, 2'd0, 4'b1111, 2'd2},  // R2 hit does not move load order
        {1'b0, 2'd0, 4'd0, 2'd0, 2'd1, 4'b1111, 2'd0},  // R3 after hit on 2
        {1'b1, 2'd0, 4'd0, 2'd0, 2'd1, 4'b1111, 2'd3},  // R3 hit 0
        {1'b0, 2'd0, 4'd0, 2'd0, 2'd2, 4'b1111, 2'd1},  // R4 counts 2,1,2,1
        {1'b1, 2'd0, 4'd0, 2'd1, 2'd2, 4'b1111, 2'd3},  // R4 hit 1, counts 2,2,2,1
        {1'b1, 2'd1, 4'd0, 2'd0, 2'd2, 4'b1111, 2'd0},  // R5 refill 0 count back to one
        {1'b0, 2'd0, 4'd0, 2'd0, 2'd0, 4'b1111, 2'd2},  // R5 load order after refill
        {1'b0, 2'd0, 4'd0, 2'd0, 2'd1, 4'b1111, 2'd3},  // R11 same state, policy switched
        {1'b1, 2'd2, 4'd0, 2'd1, 2'd2, 4'b1111, 2'd1},  // R6 invalidate 1 clears count
        {1'b0, 2'd0, 4'd1, 2'd0, 2'd0, 4'b1111, 2'd0},  // R9 set 1 untouched
        {1'b1, 2'd0, 4'd1, 2'd0, 2'd1, 4'b1111, 2'd1},  // R9 hit in set 1
        {1'b0, 2'd0, 4'd0, 2'd0, 2'd1, 4'b1111, 2'd3}   // R9 set 0 unchanged by set 1
    };
    localparam int VREQ [NV] = '{1, 1, 1, 8, 8, 2, 2, 2, 2, 3, 4, 2, 3, 3, 4, 4, 5, 5, 11, 6, 9, 9, 9};

    task automatic check(input string tag, input logic [1:0] expv);
        n_checks++;
        if (victim_way_o !== expv) begin
            n_errors++;
            $display("FAIL %s: victim=%0d expected=%0d", tag, victim_way_o, expv);
        end
    endtask

    task automatic hit(input logic [3:0] s, input logic [1:0] w);
        @(negedge clk);
        evt_valid_i = 1'b1; evt_kind_i = 2'd0; evt_set_i = s; evt_way_i = w;
        @(negedge clk);
        evt_valid_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: victim=%0d expected=done", victim_way_o);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // Table walk: drive at negedge, sample just after the next rising edge
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            evt_valid_i = VEC[i][16];
            evt_kind_i  = VEC[i][15:14];
            evt_set_i   = VEC[i][13:10];
            evt_way_i   = VEC[i][9:8];
            policy_i    = VEC[i][7:6];
            req_set_i   = VEC[i][13:10];
            req_valid_i = VEC[i][5:2];
            @(posedge clk);
            #1;
            check($sformatf("R%0d vector %0d", VREQ[i], i), VEC[i][1:0]);
        end
        @(negedge clk);
        evt_valid_i = 1'b0;

        // R7: saturation in set 2 (max count 7)
        req_set_i = 4'd2; req_valid_i = 4'hF; policy_i = 2'd2;
        for (int k = 0; k < 2; k++) hit(4'd2, 2'd0);
        for (int k = 0; k < 4; k++) hit(4'd2, 2'd2);
        for (int k = 0; k < 8; k++) hit(4'd2, 2'd1);
        #1 check("R7 after halving counts 1,4,2,0", 2'd3);
        for (int k = 0; k < 2; k++) hit(4'd2, 2'd3);
        for (int k = 0; k < 3; k++) hit(4'd2, 2'd0);
        #1 check("R7 counts 4,4,2,2", 2'd2);

        // R10: output holds until the edge that takes the event
        @(negedge clk);
        req_set_i = 4'd3; policy_i = 2'd1;
        evt_valid_i = 1'b1; evt_kind_i = 2'd0; evt_set_i = 4'd3; evt_way_i = 2'd0;
        #1 check("R10 before edge", 2'd0);
        @(posedge clk);
        #1 check("R10 after edge", 2'd1);
        @(negedge clk);
        evt_valid_i = 1'b0;

        // R8: reset restores initial state
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        req_set_i = 4'd3; policy_i = 2'd1;
        #1 check("R8 access order after reset", 2'd0);
        req_set_i = 4'd2; policy_i = 2'd2;
        #1 check("R8 counts after reset", 2'd0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule